// File: doc/BRIEF.md
# Oscillator Start-up Timer

This block qualifies a crystal oscillator before the rest of a power manager is allowed to run from it. Firmware writes a keyed control word that switches the oscillator on and supplies an 8-bit start-up count. A divide-by-eight prescaler on the slow clock paces a down-counter. When the counter expires, the block raises a clock-valid flag and a sticky interrupt flag.

The same control word carries a source-select bit. It chooses between the internal RC oscillator and the crystal as the main clock. The request only reaches the clock multiplexer once the crystal is qualified. Each change of the multiplexer is reported by a busy flag that stays high for a fixed number of destination-clock cycles, which models the synchronisation of a glitch-free switch. If the crystal loses qualification while it is in use, the multiplexer falls back to the RC source through the same handshake.

Top module: `osc_startup_timer`

## Requirements
- R1: After reset, clkStable, srcSelBusy, irq and mainSrcXtal are all 0, so the RC source is active.
- R2: A write whose key field [31:24] equals 8'hA5 and whose enable bit [0] is 1 clears clkStable in the next cycle and loads the count field [15:8]. With count N, clkStable rises at the clock edge that samples the 8*(N+1)-th slowTick pulse after the write. A pulse in the same cycle as the write is not counted.
- R3: A count of 0 sets clkStable on the first prescaled tick, which is the 8th slowTick pulse. A count of 255 takes 2048 pulses.
- R4: A write whose key field is not 8'hA5 has no effect on any state or output.
- R5: A keyed write with enable bit [0] = 0 clears clkStable and stops the counter. clkStable then stays 0 whatever slowTick does.
- R6: Select bit [1] of a keyed write is the source request. The crystal is the target only while that request is 1 and clkStable is 1. When the target differs from the active source, srcSelBusy goes high in the next cycle and stays high for exactly 2 cycles. mainSrcXtal takes the target value in the cycle after busy falls, and it changes at no other time.
- R7: If clkStable drops while the crystal is active, the block switches back to the RC source using the R6 handshake.
- R8: irq becomes 1 in the same cycle that clkStable rises and stays 1 until a cycle with statusRdEn high. If a rise coincides with a read, the set wins.
- R9: statusWord reports clkStable in bit 0, srcSelBusy in bit 1, irq in bit 2 and mainSrcXtal in bit 3.
- R10: A keyed enabling write while a count is in progress restarts the count from the new value and discards the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also taken as the destination clock for the switch handshake |
| rstN | input | 1 | Asynchronous active-low reset |
| slowTick | input | 1 | One-cycle pulse per slow-clock period, synchronous to clk |
| ctrlWrEn | input | 1 | Control-word write strobe |
| ctrlWrData | input | 32 | Control word: key [31:24], count [15:8], select [1], enable [0] |
| statusRdEn | input | 1 | Status read strobe; clears irq |
| statusWord | output | 4 | {mainSrcXtal, irq, srcSelBusy, clkStable} |
| clkStable | output | 1 | Crystal qualified |
| srcSelBusy | output | 1 | Source switch in progress |
| mainSrcXtal | output | 1 | Active main source: 1 crystal, 0 RC |
| irq | output | 1 | Sticky stable-rise interrupt flag |

## Verification
The bench builds the block with its defaults: 8-bit key and count, a prescaler of eight and a two-cycle switch handshake. With these values the full count range fits in a short run, so both count 0 and count 255 are timed exactly. It varies the slowTick spacing between every cycle and every third cycle, so prescaler phase and write timing are covered. Status reads are driven pseudo-randomly, which brings a read that coincides with the rise of clkStable, and a restart during a switch, within reach.

// File: rtl/ost_pkg.sv
package ost_pkg;
  typedef struct packed {
    logic restart;
    logic halt;
  } ctrlStrobes_t;
endpackage

// File: rtl/ost_ctrl.sv
module ost_ctrl #(
  parameter int DATA_W = 32,
  parameter int KEY_W = 8,
  parameter logic [7:0] KEY_VALUE = 8'hA5,
  parameter int COUNT_W = 8,
  parameter int COUNT_LSB = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctrlWrEn,
  input  logic [DATA_W-1:0] ctrlWrData,
  input  logic statusRdEn,
  input  logic stableSet,
  output ost_pkg::ctrlStrobes_t strobes,
  output logic [COUNT_W-1:0] loadCount,
  output logic selReq,
  output logic irq
);
  localparam int EN_BIT = 0;
  localparam int SEL_BIT = 1;
  localparam int KEY_LSB = DATA_W - KEY_W;

  logic keyOk;

  assign keyOk = ctrlWrEn && (ctrlWrData[KEY_LSB +: KEY_W] == KEY_W'(KEY_VALUE));
  assign loadCount = ctrlWrData[COUNT_LSB +: COUNT_W];

  always_comb begin
    strobes.restart = keyOk & ctrlWrData[EN_BIT];
    strobes.halt = keyOk & ~ctrlWrData[EN_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReq <= 1'b0;
    end else if (keyOk) begin
      selReq <= ctrlWrData[SEL_BIT];
    end
  end

  // the set from a stable rise wins over the clear from a read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (stableSet) begin
      irq <= 1'b1;
    end else if (statusRdEn) begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/ost_datapath.sv
module ost_datapath #(
  parameter int COUNT_W = 8,
  parameter int PRESCALE = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  ost_pkg::ctrlStrobes_t strobes,
  input  logic [COUNT_W-1:0] loadCount,
  output logic clkStable,
  output logic stableSet
);
  localparam int DIV_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);

  logic running;
  logic divTick;
  logic [DIV_W-1:0] divCnt;
  logic [COUNT_W-1:0] cnt;

  assign divTick = running & slowTick & (divCnt == DIV_LAST);
  assign stableSet = divTick & (cnt == '0) & ~strobes.restart & ~strobes.halt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt <= '0;
      cnt <= '0;
      clkStable <= 1'b0;
    end else if (strobes.restart) begin
      running <= 1'b1;
      divCnt <= '0;
      cnt <= loadCount;
      clkStable <= 1'b0;
    end else if (strobes.halt) begin
      running <= 1'b0;
      divCnt <= '0;
      clkStable <= 1'b0;
    end else begin
      if (running && slowTick) begin
        divCnt <= divTick ? '0 : divCnt + 1'b1;
      end
      if (divTick) begin
        if (cnt == '0) begin
          running <= 1'b0;
          clkStable <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ost_srcswitch.sv
module ost_srcswitch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic target,
  output logic busy,
  output logic srcActive
);
  localparam int SW_W = $clog2(SYNC_STAGES + 1);
  localparam logic [SW_W-1:0] SW_LAST = SW_W'(SYNC_STAGES - 1);

  logic [SW_W-1:0] swCnt;
  logic pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      swCnt <= '0;
      pending <= 1'b0;
      srcActive <= 1'b0;
    end else if (busy) begin
      if (swCnt == '0) begin
        busy <= 1'b0;
        srcActive <= pending;
      end else begin
        swCnt <= swCnt - 1'b1;
      end
    end else if (target != srcActive) begin
      busy <= 1'b1;
      swCnt <= SW_LAST;
      pending <= target;
    end
  end
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer #(
  parameter int DATA_W = 32,
  parameter int KEY_W = 8,
  parameter logic [7:0] KEY_VALUE = 8'hA5,
  parameter int COUNT_W = 8,
  parameter int PRESCALE = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic slowTick,
  input  logic ctrlWrEn,
  input  logic [DATA_W-1:0] ctrlWrData,
  input  logic statusRdEn,
  output logic [3:0] statusWord,
  output logic clkStable,
  output logic srcSelBusy,
  output logic mainSrcXtal,
  output logic irq
);
  ost_pkg::ctrlStrobes_t strobes;
  logic [COUNT_W-1:0] loadCount;
  logic selReq;
  logic stableSet;

  ost_ctrl #(
    .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE),
    .COUNT_W(COUNT_W), .COUNT_LSB(8)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .statusRdEn(statusRdEn), .stableSet(stableSet), .strobes(strobes),
    .loadCount(loadCount), .selReq(selReq), .irq(irq)
  );

  ost_datapath #(.COUNT_W(COUNT_W), .PRESCALE(PRESCALE)) u_dp (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .strobes(strobes),
    .loadCount(loadCount), .clkStable(clkStable), .stableSet(stableSet)
  );

  ost_srcswitch #(.SYNC_STAGES(SYNC_STAGES)) u_sw (
    .clk(clk), .rstN(rstN), .target(selReq & clkStable),
    .busy(srcSelBusy), .srcActive(mainSrcXtal)
  );

  assign statusWord = {mainSrcXtal, irq, srcSelBusy, clkStable};
endmodule

// File: rtl/ost_checker.sv
module ost_checker #(
  parameter int DATA_W = 32,
  parameter int KEY_W = 8,
  parameter logic [7:0] KEY_VALUE = 8'hA5,
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rstN,
  input logic ctrlWrEn,
  input logic [DATA_W-1:0] ctrlWrData,
  input logic clkStable,
  input logic srcSelBusy,
  input logic mainSrcXtal,
  input logic irq
);
  logic keyMatch;
  logic [7:0] busyRun;

  assign keyMatch = ctrlWrData[DATA_W-1 -: KEY_W] == KEY_W'(KEY_VALUE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else if (srcSelBusy && busyRun != 8'hFF) busyRun <= busyRun + 1'b1;
    else if (!srcSelBusy) busyRun <= '0;
  end

  p_enable_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && keyMatch) |=> !clkStable);

  p_bad_key_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !keyMatch && clkStable) |=> clkStable);

  p_src_moves_after_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(mainSrcXtal) |-> $past(srcSelBusy));

  p_busy_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    srcSelBusy |-> (busyRun < 8'(SYNC_STAGES)));

  p_irq_on_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkStable) |-> irq);
endmodule

bind osc_startup_timer ost_checker #(
  .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
  .clkStable(clkStable), .srcSelBusy(srcSelBusy), .mainSrcXtal(mainSrcXtal), .irq(irq)
);

// File: tb/osc_startup_timer_bench.sv
module osc_startup_timer_bench;
  localparam int PRE = 8;
  localparam int SYNC = 2;
  localparam logic [7:0] KEY = 8'hA5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic slowTick = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic statusRdEn = 1'b0;
  logic [3:0] statusWord;
  logic clkStable, srcSelBusy, mainSrcXtal, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tickDiv = 1;
  bit tickOn = 0;
  bit rdRandom = 0;
  bit rdForce = 0;
  bit done = 0;
  logic [7:0] lfsr = 8'h5B;

  // reference model state
  int mStable = 0, mRun = 0, mRemain = 0, mSel = 0, mIrq = 0;
  int mSrc = 0, mBusyLeft = 0, mPend = 0;

  always #2.5 clk = ~clk;

  osc_startup_timer u_osc_startup_timer (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .ctrlWrEn(ctrlWrEn),
    .ctrlWrData(ctrlWrData), .statusRdEn(statusRdEn), .statusWord(statusWord),
    .clkStable(clkStable), .srcSelBusy(srcSelBusy), .mainSrcXtal(mainSrcXtal), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    int target;
    bit keyOk;
    bit rose;
    if (!rstN) begin
      mStable = 0; mRun = 0; mRemain = 0; mSel = 0; mIrq = 0;
      mSrc = 0; mBusyLeft = 0; mPend = 0;
    end else begin
      keyOk = ctrlWrEn && (ctrlWrData[31:24] == KEY);
      target = (mSel != 0 && mStable != 0) ? 1 : 0;
      if (mBusyLeft > 0) begin
        mBusyLeft--;
        if (mBusyLeft == 0) mSrc = mPend;
      end else if (target != mSrc) begin
        mBusyLeft = SYNC;
        mPend = target;
      end
      rose = 0;
      if (keyOk) begin
        mSel = int'(ctrlWrData[1]);
        mStable = 0;
        if (ctrlWrData[0]) begin
          mRun = 1;
          mRemain = (int'(ctrlWrData[15:8]) + 1) * PRE;
        end else begin
          mRun = 0;
        end
      end else if (mRun != 0 && slowTick) begin
        mRemain--;
        if (mRemain == 0) begin
          mRun = 0; mStable = 1; rose = 1;
        end
      end
      if (rose) mIrq = 1;
      else if (statusRdEn) mIrq = 0;
    end
  end

  // compare and drive free-running inputs away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      check("R2 clkStable", int'(clkStable), mStable);
      check("R6 srcSelBusy", int'(srcSelBusy), (mBusyLeft > 0) ? 1 : 0);
      check("R6 R7 mainSrcXtal", int'(mainSrcXtal), mSrc);
      check("R8 irq", int'(irq), mIrq);
      check("R9 statusWord", int'(statusWord),
            mStable + ((mBusyLeft > 0) ? 2 : 0) + 4 * mIrq + 8 * mSrc);
    end
    slowTick <= tickOn && (cyc % tickDiv == 0);
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    statusRdEn <= rdForce || (rdRandom && lfsr[0] && lfsr[2]);
  end

  initial begin
    int w;
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    w = 0;
  end

  task automatic wr(input logic [7:0] key, input int cnt, input bit sel, input bit en);
    ctrlWrData <= {key, 8'h00, 8'(cnt), 6'b0, sel, en};
    ctrlWrEn <= 1'b1;
    @(negedge clk);
    ctrlWrEn <= 1'b0;
    ctrlWrData <= '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // measure negedges until clkStable after a write returns
  task automatic timeStable(input string req, input int expCycles);
    int n = 0;
    while (!clkStable && n < 10000) begin
      @(negedge clk);
      n++;
    end
    check(req, n, expCycles);
  endtask

  initial begin
    idle(3);
    check("R1 clkStable", int'(clkStable), 0);
    check("R1 srcSelBusy", int'(srcSelBusy), 0);
    check("R1 mainSrcXtal", int'(mainSrcXtal), 0);
    check("R1 irq", int'(irq), 0);
    rstN = 1'b1;
    idle(2);
    tickOn = 1; tickDiv = 1;
    idle(2);

    // R3 count 0: eight pulses, one per cycle
    wr(KEY, 0, 0, 1);
    timeStable("R3 count zero", 8);
    check("R8 irq after rise", int'(irq), 1);
    rdForce = 1; idle(1); rdForce = 0; idle(1);
    check("R8 irq cleared by read", int'(irq), 0);

    // R2 and R6: count 2 with select, then switch to crystal
    wr(KEY, 2, 1, 1);
    check("R2 cleared by write", int'(clkStable), 0);
    timeStable("R2 count two", 24);
    idle(8);
    check("R6 crystal active", int'(mainSrcXtal), 1);

    // R4: wrong key, disabling payload ignored
    wr(8'h5A, 0, 0, 0);
    idle(20);
    check("R4 stable kept", int'(clkStable), 1);
    check("R4 source kept", int'(mainSrcXtal), 1);

    // R7: restart drops qualification, fall back to RC
    wr(KEY, 3, 1, 1);
    idle(6);
    check("R7 fallback to RC", int'(mainSrcXtal), 0);
    timeStable("R7 requalify", 26);
    idle(8);
    check("R7 back on crystal", int'(mainSrcXtal), 1);

    // R10: restart mid-count with a smaller value
    wr(KEY, 6, 1, 1);
    idle(11);
    wr(KEY, 1, 1, 1);
    timeStable("R10 restart count", 16);

    // slower pulses, random reads
    tickDiv = 3; rdRandom = 1;
    wr(KEY, 5, 1, 1);
    idle(200);
    check("R2 slow pulses stable", int'(clkStable), 1);
    wr(KEY, 0, 0, 1);
    idle(40);

    // R5: disable, pulses keep coming
    wr(KEY, 0, 1, 0);
    idle(150);
    check("R5 stays unqualified", int'(clkStable), 0);
    check("R5 on RC", int'(mainSrcXtal), 0);

    // R3 count 255 at one pulse per cycle
    tickDiv = 1; rdRandom = 0;
    wr(KEY, 255, 0, 1);
    timeStable("R3 count max", 2048);
    rdRandom = 1;
    idle(60);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule